// File: doc/BRIEF.md
# Bitplane Pixel Plot Unit

The unit writes one pixel into a frame buffer that holds graphics as 8x8 tiles, each tile storing its colour bits as separate bitplanes interleaved in pairs. A caller presents a plot request with the pixel coordinate and a colour. It also supplies the tile-row base for the current y and the tile-column offset for the current x, which it looks up in its own tables. Along with these come a small option word and a colour depth of 2, 4 or 8 bits per pixel. The unit forms the tile byte address and the bit mask for the pixel. It then picks the colour, with an optional checkerboard dither in the 2-bit depth, and decides whether the pixel is transparent. For every plane of the selected depth it reads the byte over a single byte-wide memory port, then writes it back with the pixel bit set or cleared.

After each plot the unit presents the next x coordinate, which is the plotted x plus one. This holds also when a transparent pixel produces no memory traffic. A one-cycle done pulse marks the end of each plot. The unit also reports the effective screen height, which is forced to 256 lines when the sprite option is on.

Top module: `bitplane_plot`

## Requirements
- R1: For plane k, the byte address is row_base_i + col_off_i + 2*(y_i mod 8) + ofs(k). Here ofs(k) = 16*(k div 2) + (k mod 2), so planes 0..7 sit at offsets 0x00, 0x01, 0x10, 0x11, 0x20, 0x21, 0x30, 0x31.
- R2: The pixel mask is 0x80 shifted right by (x_i mod 8), so pixel 0 is the most significant bit. A written byte differs from the byte read at that address only in the mask bit.
- R3: In plane k the mask bit is written as 1 when bit k of the colour in use is 1, and as 0 otherwise.
- R4: depth_i = 0 selects 2 planes, 1 selects 4 planes, and 2 or 3 selects 8 planes. The planes are handled in ascending order, each as a read followed in the next cycle by a write to the same address. mem_rdata_i is valid in the cycle after mem_rd_o.
- R5: When option bit 1 (dither) is set, depth is 0, and bit 0 of (x_i XOR y_i) is 1, the colour in use is color_i[7:4]. In every other case it is color_i. Dither has no effect at depths 1..3.
- R6: At depths 0 and 1, with option bit 0 (opaque) clear, a colour in use whose low nibble is zero skips the pixel and causes no memory access.
- R7: At depths 2 and 3, with option bit 0 clear, the transparency test looks at the low nibble when option bit 4 is clear and at the whole byte when option bit 4 is set. Option bit 0 set disables every transparency test.
- R8: After every plot, skipped or not, x_o equals the accepted x_i plus one, wrapping at the width of x.
- R9: eff_height_o is 256 when opt_i bit 4 is set, and native_height_i otherwise.
- R10: done_o pulses for one cycle. It comes 1 cycle after acceptance for a skipped pixel, and 2N+1 cycles after acceptance for N planes. A request is accepted only while busy_o is low; a request raised while busy_o is high is ignored.
- R11: After reset, done_o, busy_o, mem_rd_o, mem_wr_o and x_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Plot request |
| x_i | input | XW | Pixel x |
| y_i | input | YW | Pixel y |
| row_base_i | input | AW | Tile-row base for y div 8 |
| col_off_i | input | AW | Tile-column offset for x div 8 |
| color_i | input | 8 | Colour register |
| opt_i | input | 5 | Options: bit0 opaque, bit1 dither, bit4 sprite/full-byte test |
| depth_i | input | 2 | Colour depth select |
| native_height_i | input | HW | Screen height outside sprite mode |
| busy_o | output | 1 | Plane traffic in progress |
| done_o | output | 1 | Plot finished pulse |
| x_o | output | XW | Next x coordinate |
| eff_height_o | output | HW | Effective screen height |
| mem_addr_o | output | AW | Byte address |
| mem_rd_o | output | 1 | Read strobe |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_rd_o |

## Verification
The assertions take for granted that the memory returns read data in the cycle after the read strobe and holds no other writer between a plane read and its write. The masked-write check relies on this. They also assume that request fields are stable during the accepting cycle. The stimulus uses a private byte memory with a one-cycle read and holds every request field steady from the negedge before acceptance. It keeps all addresses inside that memory and issues new requests only after done. The one exception is a deliberate intrusion while busy, which tests that the intruding request is ignored.

// File: rtl/plot_pkg.sv
package plot_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} seq_st_e;

  // single set bit for pixel column within a byte, pixel 0 is the MSB
  function automatic logic [7:0] bit_mask(input logic [2:0] col);
    return 8'h80 >> col;
  endfunction

  // byte offset of plane k from the tile row address
  function automatic logic [5:0] plane_ofs(input logic [2:0] k);
    return {k[2:1], 3'b000, k[0]};
  endfunction

  function automatic logic [3:0] plane_count(input logic [1:0] depth);
    case (depth)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [7:0] pick_color(input logic [7:0] color,
                                            input logic dith, input logic two_bit,
                                            input logic parity);
    if (dith && two_bit && parity) return {4'h0, color[7:4]};
    return color;
  endfunction

  function automatic logic skip_px(input logic [7:0] col, input logic opaque,
                                   input logic full_test, input logic eight_bit);
    if (opaque) return 1'b0;
    if (eight_bit && full_test) return col == 8'h00;
    return col[3:0] == 4'h0;
  endfunction
endpackage

// File: rtl/plot_setup.sv
module plot_setup
  import plot_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    x_lo,
  input  logic [2:0]    y_lo,
  input  logic [AW-1:0] row_base,
  input  logic [AW-1:0] col_off,
  input  logic [7:0]    color,
  input  logic          opaque,
  input  logic          dith,
  input  logic          full_test,
  input  logic [1:0]    depth,
  output logic [AW-1:0] tile,
  output logic [7:0]    mask,
  output logic [7:0]    eff_col,
  output logic          skip,
  output logic [3:0]    nplanes
);
  logic two_bit, eight_bit, parity;

  assign two_bit   = (depth == 2'd0);
  assign eight_bit = depth[1];
  assign parity    = x_lo[0] ^ y_lo[0];

  assign tile    = row_base + col_off + AW'({y_lo, 1'b0});
  assign mask    = bit_mask(x_lo);
  assign eff_col = pick_color(color, dith, two_bit, parity);
  assign skip    = skip_px(eff_col, opaque, full_test, eight_bit);
  assign nplanes = plane_count(depth);
endmodule

// File: rtl/plot_seq.sv
module plot_seq
  import plot_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          skip,
  input  logic [3:0]    nplanes,
  input  logic [AW-1:0] tile,
  input  logic [7:0]    mask,
  input  logic [7:0]    color,
  input  logic [7:0]    rdata,
  output logic [AW-1:0] addr,
  output logic          rd,
  output logic          wr,
  output logic [7:0]    wdata,
  output logic          done,
  output logic          busy,
  output logic          last_wr
);
  seq_st_e       st_q;
  logic [2:0]    k_q;
  logic [3:0]    n_q;
  logic [AW-1:0] tile_q;
  logic [7:0]    mask_q, col_q;

  assign rd      = (st_q == ST_RD);
  assign wr      = (st_q == ST_WR);
  assign done    = (st_q == ST_FIN);
  assign busy    = rd | wr;
  assign addr    = tile_q + AW'(plane_ofs(k_q));
  assign wdata   = col_q[k_q] ? (rdata | mask_q) : (rdata & ~mask_q);
  assign last_wr = wr && ({1'b0, k_q} == n_q - 4'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      k_q    <= '0;
      n_q    <= '0;
      tile_q <= '0;
      mask_q <= '0;
      col_q  <= '0;
    end else begin
      case (st_q)
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (last_wr) st_q <= ST_FIN;
          else begin
            k_q  <= k_q + 3'd1;
            st_q <= ST_RD;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (start && !busy) begin
        tile_q <= tile;
        mask_q <= mask;
        col_q  <= color;
        n_q    <= nplanes;
        k_q    <= '0;
        st_q   <= skip ? ST_FIN : ST_RD;
      end
    end
  end

  // R4
  wr_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> ($past(rd) && $stable(addr)));
  // R2
  masked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |-> (((wdata ^ rdata) & ~mask_q) == 8'h00));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !done);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd);
endmodule

// File: rtl/bitplane_plot.sv
module bitplane_plot
  import plot_pkg::*;
#(
  parameter int AW = 16,
  parameter int XW = 8,
  parameter int YW = 8,
  parameter int HW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [XW-1:0] x_i,
  input  logic [YW-1:0] y_i,
  input  logic [AW-1:0] row_base_i,
  input  logic [AW-1:0] col_off_i,
  input  logic [7:0]    color_i,
  input  logic [4:0]    opt_i,
  input  logic [1:0]    depth_i,
  input  logic [HW-1:0] native_height_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [XW-1:0] x_o,
  output logic [HW-1:0] eff_height_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam logic [HW-1:0] SPRITE_H = HW'(256);

  logic [AW-1:0] tile;
  logic [7:0]    mask, eff_col;
  logic          skip, accept, last_wr;
  logic [3:0]    nplanes;
  logic [XW-1:0] x_q;
  logic          unused_bits;

  assign unused_bits  = ^{opt_i[3:2], y_i[YW-1:3]};
  assign accept       = req_i && !busy_o;
  assign eff_height_o = opt_i[4] ? SPRITE_H : native_height_i;

  plot_setup #(.AW(AW)) setup_i (
    .x_lo(x_i[2:0]), .y_lo(y_i[2:0]), .row_base(row_base_i), .col_off(col_off_i),
    .color(color_i), .opaque(opt_i[0]), .dith(opt_i[1]), .full_test(opt_i[4]),
    .depth(depth_i), .tile(tile), .mask(mask), .eff_col(eff_col), .skip(skip),
    .nplanes(nplanes)
  );

  plot_seq #(.AW(AW)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(req_i), .skip(skip), .nplanes(nplanes),
    .tile(tile), .mask(mask), .color(eff_col), .rdata(mem_rdata_i),
    .addr(mem_addr_o), .rd(mem_rd_o), .wr(mem_wr_o), .wdata(mem_wdata_o),
    .done(done_o), .busy(busy_o), .last_wr(last_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      x_o <= '0;
    end else begin
      if (accept) x_q <= x_i;
      if (accept && skip) x_o <= x_i + XW'(1);
      else if (last_wr)   x_o <= x_q + XW'(1);
    end
  end

  // R6
  skip_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && skip) |=> (done_o && !mem_rd_o && !mem_wr_o));
  // R8
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (x_o == x_q + XW'(1)));
endmodule

// File: tb/bitplane_plot_tb_top.sv
module bitplane_plot_tb_top;
  localparam int AW = 16, XW = 8, YW = 8, HW = 9;

  logic clk = 0, rst_n = 0, req = 0;
  logic [XW-1:0] x = 0;
  logic [YW-1:0] y = 0;
  logic [AW-1:0] rb = 0, co = 0;
  logic [7:0] color = 0;
  logic [4:0] opt = 0;
  logic [1:0] depth = 0;
  logic [HW-1:0] nat_h = 9'd224;
  logic busy, done, mem_rd, mem_wr;
  logic [XW-1:0] x_o;
  logic [HW-1:0] eff_h;
  logic [AW-1:0] mem_addr;
  logic [7:0] wdata, rdata = 0;

  int checks = 0, fails = 0;
  logic [7:0] ram [0:1023];
  logic [7:0] model [0:1023];
  logic [AW-1:0] q_addr[$];
  logic [7:0] q_data[$];

  always #5 clk = ~clk;

  bitplane_plot #(.AW(AW), .XW(XW), .YW(YW), .HW(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req), .x_i(x), .y_i(y), .row_base_i(rb),
    .col_off_i(co), .color_i(color), .opt_i(opt), .depth_i(depth),
    .native_height_i(nat_h), .busy_o(busy), .done_o(done), .x_o(x_o),
    .eff_height_o(eff_h), .mem_addr_o(mem_addr), .mem_rd_o(mem_rd),
    .mem_wr_o(mem_wr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) rdata <= ram[mem_addr[9:0]];
    if (mem_wr) ram[mem_addr[9:0]] <= wdata;
  end

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
    end
  endtask

  // monitor: pops expected writes as they appear
  always @(negedge clk) begin
    if (rst_n && mem_wr) begin
      if (q_addr.size() == 0) check(0, "R6/R10 unexpected write", int'(mem_addr), 0);
      else begin
        automatic logic [AW-1:0] ea = q_addr.pop_front();
        automatic logic [7:0] ed = q_data.pop_front();
        check(mem_addr == ea, "R1 address", int'(mem_addr), int'(ea));
        check(wdata == ed, "R3 plane data", int'(wdata), int'(ed));
      end
    end
  end

  task automatic plot(input logic [7:0] px, input logic [7:0] py, input logic [AW-1:0] prb,
                      input logic [AW-1:0] pco, input logic [7:0] pc, input logic [4:0] po,
                      input logic [1:0] pd, input bit intrude);
    logic [7:0] c, m;
    bit sk;
    int n, np, expn;
    logic [AW-1:0] base, a;
    c = (po[1] && pd == 0 && ((px[0] ^ py[0]) == 1'b1)) ? {4'h0, pc[7:4]} : pc;
    if (po[0]) sk = 0;
    else if (pd >= 2 && po[4]) sk = (c == 0);
    else sk = (c[3:0] == 0);
    np = (pd == 0) ? 2 : (pd == 1) ? 4 : 8;
    m = 8'h80 >> px[2:0];
    base = prb + pco + AW'(2 * int'(py[2:0]));
    if (!sk) begin
      for (int k = 0; k < np; k++) begin
        a = base + AW'(16 * (k / 2) + (k % 2));
        model[a[9:0]] = c[k] ? (model[a[9:0]] | m) : (model[a[9:0]] & ~m);
        q_addr.push_back(a);
        q_data.push_back(model[a[9:0]]);
      end
    end
    expn = sk ? 1 : 2 * np + 1;
    @(negedge clk);
    x = px; y = py; rb = prb; co = pco; color = pc; opt = po; depth = pd; req = 1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      req = 0;
      if (intrude && n == 2) begin
        req = 1; x = 8'd99; y = 8'd1; rb = 16'd300; color = 8'hFF; opt = 5'd1;
      end
    end while (!done && n < 40);
    check(n == expn, "R10 done latency", n, expn);
    check(x_o == px + 8'd1, "R8 next x", int'(x_o), int'(px + 8'd1));
    check(q_addr.size() == 0, "R4 plane count", q_addr.size(), 0);
    q_addr.delete(); q_data.delete();
    req = 0;
  endtask

  initial begin
    #2000000;
    check(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin
      ram[i] = 8'(i * 29 + 7);
      model[i] = 8'(i * 29 + 7);
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11
    check(!done && !busy && !mem_rd && !mem_wr, "R11 reset strobes", {done, busy, mem_rd, mem_wr}, 0);
    check(x_o == 0, "R11 reset x", int'(x_o), 0);
    // R9
    opt = 5'h10; #1;
    check(eff_h == 9'd256, "R9 sprite height", int'(eff_h), 256);
    opt = 5'h00; #1;
    check(eff_h == 9'd224, "R9 native height", int'(eff_h), 224);
    // R1 R2 R3 R4: 2, 4, 8 and depth-3 planes
    plot(8'd3, 8'd5, 16'd64, 16'd8, 8'h02, 5'h00, 2'd0, 0);
    plot(8'd10, 8'd2, 16'd128, 16'd0, 8'h0A, 5'h00, 2'd1, 0);
    plot(8'd7, 8'd7, 16'd256, 16'd32, 8'hA5, 5'h00, 2'd2, 0);
    plot(8'd0, 8'd3, 16'd512, 16'd64, 8'h5A, 5'h00, 2'd3, 0);
    // R5 dither: odd parity uses upper nibble, even parity lower
    plot(8'd1, 8'd0, 16'd600, 16'd0, 8'h31, 5'h02, 2'd0, 0);
    plot(8'd2, 8'd0, 16'd600, 16'd0, 8'h32, 5'h02, 2'd0, 0);
    // R5 dither has no effect at 4 bits: low nibble 0 stays transparent
    plot(8'd1, 8'd0, 16'd640, 16'd0, 8'h30, 5'h02, 2'd1, 0);
    // R6 transparency and opaque override
    plot(8'd4, 8'd4, 16'd700, 16'd0, 8'h10, 5'h00, 2'd0, 0);
    plot(8'd4, 8'd4, 16'd700, 16'd0, 8'h10, 5'h01, 2'd0, 0);
    // R7 eight-bit transparency variants
    plot(8'd5, 8'd1, 16'd760, 16'd0, 8'hF0, 5'h00, 2'd2, 0);
    plot(8'd5, 8'd1, 16'd760, 16'd0, 8'hF0, 5'h10, 2'd2, 0);
    plot(8'd6, 8'd1, 16'd760, 16'd0, 8'h00, 5'h10, 2'd2, 0);
    plot(8'd6, 8'd1, 16'd760, 16'd0, 8'h00, 5'h11, 2'd2, 0);
    // R8 wrap of x
    plot(8'd255, 8'd6, 16'd820, 16'd0, 8'h03, 5'h00, 2'd0, 0);
    // R10 request while busy is ignored
    plot(8'd9, 8'd2, 16'd880, 16'd0, 8'h06, 5'h00, 2'd1, 1);
    repeat (3) @(negedge clk);
    check(!busy && !done, "R10 idle after ignored request", {busy, done}, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule